// File: doc/BRIEF.md
# Ripple-Carry Adder Structured Self-Test Controller

This block is a built-in self-test sequencer that sits beside a W-bit ripple-carry adder. After a one-cycle start request it drives the adder's two operands and carry input through a fixed list of ten deterministic vectors, one vector per clock. The vectors are grouped by equivalence class, so every full-adder cell is exercised on all eight of its input combinations in parallel and every carry link between cells carries both a 0 and a 1. Neither exhaustive nor random operands are needed.

The adder's sum and carry-out are registered together with a reference result. The reference is the (W+1)-bit arithmetic sum of the applied operands and carry. That captured comparison updates the status one cycle later. The controller keeps a count of failing vectors, the number of the earliest failing vector, and busy, done, pass and fail flags. The adder itself is outside the block and is connected through the stimulus outputs and the observation inputs.

Top module: `adder_selftest`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the controller to idle: busy, done, pass and fail are 0, and vec_idx, fail_count and first_fail are 0.
- R2: A start pulse seen while idle makes vec_idx read 1 in the next cycle. It then advances by one each cycle up to 10, followed by one drain cycle with vec_idx 0. Busy is high for exactly 11 cycles.
- R3: Vectors 1, 2 and 3 apply carry-in 0 with (a, b) equal to (all zeros, all zeros), (all zeros, all ones) and (all ones, all zeros).
- R4: Vectors 4, 5 and 6 apply carry-in 1 with (a, b) equal to (all ones, all zeros), (all zeros, all ones) and (all ones, all ones).
- R5: Vectors 7 to 10 apply a = b. P is the pattern with bit 0 set and alternating bits (...0101), and Q is its complement. Vector 7 is P with carry 0, vector 8 is Q with carry 1, vector 9 is Q with carry 0, and vector 10 is P with carry 1.
- R6: A vector fails when {carry-out, sum} from the adder differs from a + b + carry-in computed over W+1 bits, so carry-out is checked as well as the sum. fail_count (4 bits) counts failing vectors in the run, and fail rises once it is nonzero.
- R7: first_fail holds the number (1 to 10) of the earliest failing vector of the run, or 0 when none has failed.
- R8: One cycle after busy falls, done is 1. Done stays 1 until the next start. Pass is 1 exactly when done is 1 and fail_count is 0.
- R9: A start pulse while busy is ignored: the vector order, the busy length and the status are unchanged.
- R10: A start pulse while done is high clears fail_count, first_fail, fail and done in the next cycle, and a new run begins.
- R11: Outside the 10 vector cycles, the stimulus outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a test run |
| obs_sum | input | W | Sum returned by the adder under test |
| obs_cout | input | 1 | Carry-out returned by the adder under test |
| tst_a | output | W | Operand A applied to the adder |
| tst_b | output | W | Operand B applied to the adder |
| tst_cin | output | 1 | Carry-in applied to the adder |
| vec_idx | output | 4 | Number of the vector now applied, 0 when none |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Finished run with no failing vector |
| fail | output | 1 | At least one vector failed in this run |
| fail_count | output | 4 | Number of failing vectors in this run |
| first_fail | output | 4 | Number of the earliest failing vector, 0 if none |

## Verification
The bench drives a behavioural adder whose faults it can select, and each fault lights up a different subset of vectors. A flipped sum bit fails all ten vectors. A carry link broken at an even cell fails only the vectors that carry into that cell (4, 5, 6, 8, 9), so a controller with a wrong alternating pattern or a wrong carry-in per vector reports the wrong count or the wrong first failure. An inverted carry-out catches a controller that ignores carry-out. A start pulse in the middle of a run, a restart straight after a failing run, and a reset in the middle of a run catch a sequencer that restarts, stretches busy, or keeps stale status.

// File: rtl/adder_selftest_pkg.sv
package adder_selftest_pkg;
  localparam int unsigned NUM_VEC = 10;
  localparam int unsigned IDX_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/selftest_seq.sv
module selftest_seq
  import adder_selftest_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] idx,
  output logic             issue,
  output logic             launch,
  output logic             finish,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VEC);

  seq_state_e state_q;

  // a start is honoured only from idle
  assign launch = (state_q == ST_IDLE) && start;
  assign issue  = (state_q == ST_RUN);
  assign finish = (state_q == ST_DRAIN);
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            idx     <= IDX_W'(1);
          end
        end
        ST_RUN: begin
          if (idx == LAST_IDX) begin
            state_q <= ST_DRAIN;
            idx     <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/selftest_vecgen.sv
module selftest_vecgen
  import adder_selftest_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             active,
  output logic [W-1:0]     vec_a,
  output logic [W-1:0]     vec_b,
  output logic             vec_cin
);
  // pattern with bit 0 set and alternating upward: ...0101
  function automatic logic [W-1:0] odd_pattern();
    logic [W-1:0] p;
    for (int i = 0; i < int'(W); i++) p[i] = (i % 2 == 0);
    return p;
  endfunction

  localparam logic [W-1:0] ZEROS = '0;
  localparam logic [W-1:0] ONES  = '1;
  localparam logic [W-1:0] PAT_P = odd_pattern();
  localparam logic [W-1:0] PAT_Q = ~odd_pattern();

  always_comb begin
    vec_a   = ZEROS;
    vec_b   = ZEROS;
    vec_cin = 1'b0;
    if (active) begin
      unique case (idx)
        4'd1:  begin vec_a = ZEROS; vec_b = ZEROS; vec_cin = 1'b0; end
        4'd2:  begin vec_a = ZEROS; vec_b = ONES;  vec_cin = 1'b0; end
        4'd3:  begin vec_a = ONES;  vec_b = ZEROS; vec_cin = 1'b0; end
        4'd4:  begin vec_a = ONES;  vec_b = ZEROS; vec_cin = 1'b1; end
        4'd5:  begin vec_a = ZEROS; vec_b = ONES;  vec_cin = 1'b1; end
        4'd6:  begin vec_a = ONES;  vec_b = ONES;  vec_cin = 1'b1; end
        4'd7:  begin vec_a = PAT_P; vec_b = PAT_P; vec_cin = 1'b0; end
        4'd8:  begin vec_a = PAT_Q; vec_b = PAT_Q; vec_cin = 1'b1; end
        4'd9:  begin vec_a = PAT_Q; vec_b = PAT_Q; vec_cin = 1'b0; end
        4'd10: begin vec_a = PAT_P; vec_b = PAT_P; vec_cin = 1'b1; end
        default: begin vec_a = ZEROS; vec_b = ZEROS; vec_cin = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/selftest_check.sv
module selftest_check
  import adder_selftest_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     vec_a,
  input  logic [W-1:0]     vec_b,
  input  logic             vec_cin,
  input  logic [W-1:0]     obs_sum,
  input  logic             obs_cout,
  output logic             chk_valid,
  output logic [IDX_W-1:0] chk_idx,
  output logic             chk_miss
);
  function automatic logic [W:0] ref_add(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic         c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  logic [W:0] ref_result;
  logic       miss_now;

  assign ref_result = ref_add(vec_a, vec_b, vec_cin);
  assign miss_now   = (ref_result != {obs_cout, obs_sum});

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid <= 1'b0;
      chk_idx   <= '0;
      chk_miss  <= 1'b0;
    end else begin
      chk_valid <= issue;
      chk_idx   <= idx;
      chk_miss  <= issue && miss_now;
    end
  end
endmodule

// File: rtl/selftest_status.sv
module selftest_status
  import adder_selftest_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             finish,
  input  logic             chk_valid,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             chk_miss,
  output logic [IDX_W-1:0] fail_count,
  output logic [IDX_W-1:0] first_fail,
  output logic             done
);
  logic count_evt;
  assign count_evt = chk_valid && chk_miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_count <= '0;
      first_fail <= '0;
      done       <= 1'b0;
    end else if (clear) begin
      fail_count <= '0;
      first_fail <= '0;
      done       <= 1'b0;
    end else begin
      if (count_evt) begin
        if (fail_count == '0) first_fail <= chk_idx;
        fail_count <= fail_count + IDX_W'(1);
      end
      if (finish) done <= 1'b1;
    end
  end
endmodule

// File: rtl/adder_selftest.sv
module adder_selftest
  import adder_selftest_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] obs_sum,
  input  logic         obs_cout,
  output logic [W-1:0] tst_a,
  output logic [W-1:0] tst_b,
  output logic         tst_cin,
  output logic [3:0]   vec_idx,
  output logic         busy,
  output logic         done,
  output logic         pass,
  output logic         fail,
  output logic [3:0]   fail_count,
  output logic [3:0]   first_fail
);
  // internal events, named for the checker
  logic             ev_issue;
  logic             ev_launch;
  logic             ev_finish;
  logic             ev_chk_valid;
  logic             ev_chk_miss;
  logic [IDX_W-1:0] ev_chk_idx;
  logic [IDX_W-1:0] seq_idx;

  selftest_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .idx    (seq_idx),
    .issue  (ev_issue),
    .launch (ev_launch),
    .finish (ev_finish),
    .busy   (busy)
  );

  selftest_vecgen #(.W(W)) u_vecgen (
    .idx     (seq_idx),
    .active  (ev_issue),
    .vec_a   (tst_a),
    .vec_b   (tst_b),
    .vec_cin (tst_cin)
  );

  selftest_check #(.W(W)) u_check (
    .clk       (clk),
    .rst       (rst),
    .issue     (ev_issue),
    .idx       (seq_idx),
    .vec_a     (tst_a),
    .vec_b     (tst_b),
    .vec_cin   (tst_cin),
    .obs_sum   (obs_sum),
    .obs_cout  (obs_cout),
    .chk_valid (ev_chk_valid),
    .chk_idx   (ev_chk_idx),
    .chk_miss  (ev_chk_miss)
  );

  selftest_status u_status (
    .clk        (clk),
    .rst        (rst),
    .clear      (ev_launch),
    .finish     (ev_finish),
    .chk_valid  (ev_chk_valid),
    .chk_idx    (ev_chk_idx),
    .chk_miss   (ev_chk_miss),
    .fail_count (fail_count),
    .first_fail (first_fail),
    .done       (done)
  );

  assign vec_idx = seq_idx;
  assign fail    = (fail_count != '0);
  assign pass    = done && (fail_count == '0);
endmodule

// File: rtl/adder_selftest_chk.sv
module adder_selftest_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] tst_a,
  input logic [W-1:0] tst_b,
  input logic         tst_cin,
  input logic [3:0]   vec_idx,
  input logic         busy,
  input logic         done,
  input logic         pass,
  input logic [3:0]   fail_count,
  input logic [3:0]   first_fail,
  input logic         ev_issue,
  input logic         ev_chk_valid,
  input logic         ev_chk_miss
);
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && vec_idx >= 4'd1 && vec_idx <= 4'd9) |=> (vec_idx == $past(vec_idx) + 4'd1));

  assert_run_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && vec_idx >= 4'd1 && vec_idx <= 4'd9) |=> busy);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (fail_count == $past(fail_count) || fail_count == $past(fail_count) + 4'd1));

  assert_miss_counts_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_chk_valid && ev_chk_miss) |=> (fail_count != 4'd0));

  assert_first_range_R7: assert property (@(posedge clk) disable iff (rst)
    (fail_count != 4'd0) |-> (first_fail >= 4'd1 && first_fail <= 4'd10));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  assert_pass_ok_R8: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && fail_count == 4'd0));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !ev_issue |-> (tst_a == '0 && tst_b == '0 && !tst_cin));
endmodule

bind adder_selftest adder_selftest_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .tst_a        (tst_a),
  .tst_b        (tst_b),
  .tst_cin      (tst_cin),
  .vec_idx      (vec_idx),
  .busy         (busy),
  .done         (done),
  .pass         (pass),
  .fail_count   (fail_count),
  .first_fail   (first_fail),
  .ev_issue     (ev_issue),
  .ev_chk_valid (ev_chk_valid),
  .ev_chk_miss  (ev_chk_miss)
);

// File: tb/adder_selftest_bench.sv
module adder_selftest_bench;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] obs_sum;
  logic         obs_cout;
  logic [W-1:0] tst_a, tst_b;
  logic         tst_cin;
  logic [3:0]   vec_idx, fail_count, first_fail;
  logic         busy, done, pass, fail;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int fault_mode = 0;   // 0 good, 1 sum bit 5 flipped, 2 carry into bit 4 cut, 3 carry-out inverted

  always #4 clk = ~clk;   // 125 MHz

  adder_selftest #(.W(W)) u_adder_selftest (
    .clk(clk), .rst(rst), .start(start), .obs_sum(obs_sum), .obs_cout(obs_cout),
    .tst_a(tst_a), .tst_b(tst_b), .tst_cin(tst_cin), .vec_idx(vec_idx),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_count(fail_count), .first_fail(first_fail)
  );

  function automatic logic [W:0] model_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic c, input int mode);
    logic [W:0] r;
    logic [4:0] lo;
    logic [W-4:0] hi;
    r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    case (mode)
      1: r[5] = ~r[5];
      2: begin
        lo = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, c};
        hi = {1'b0, a[W-1:4]} + {1'b0, b[W-1:4]};
        r  = {hi, lo[3:0]};
      end
      3: r[W] = ~r[W];
      default: ;
    endcase
    return r;
  endfunction

  always_comb {obs_cout, obs_sum} = model_add(tst_a, tst_b, tst_cin, fault_mode);

  typedef struct {
    logic [3:0]   idx;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
  } vec_item_t;

  vec_item_t sb_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected vector n, written from the requirement tables
  function automatic vec_item_t expect_vec(input int n);
    vec_item_t v;
    logic [W-1:0] p, q;
    p = {(W/2){2'b01}};
    q = {(W/2){2'b10}};
    v.idx = 4'(n);
    case (n)
      1:  begin v.a = '0; v.b = '0; v.c = 0; end   // R3
      2:  begin v.a = '0; v.b = '1; v.c = 0; end   // R3
      3:  begin v.a = '1; v.b = '0; v.c = 0; end   // R3
      4:  begin v.a = '1; v.b = '0; v.c = 1; end   // R4
      5:  begin v.a = '0; v.b = '1; v.c = 1; end   // R4
      6:  begin v.a = '1; v.b = '1; v.c = 1; end   // R4
      7:  begin v.a = p;  v.b = p;  v.c = 0; end   // R5
      8:  begin v.a = q;  v.b = q;  v.c = 1; end   // R5
      9:  begin v.a = q;  v.b = q;  v.c = 0; end   // R5
      default: begin v.a = p; v.b = p; v.c = 1; end // R5
    endcase
    return v;
  endfunction

  // monitor: each cycle with a vector applied pops the next expected item
  always @(negedge clk) begin
    if (!rst && vec_idx != 4'd0) begin
      if (sb_q.size() == 0) begin
        check(0, "R2 unexpected vector", longint'(vec_idx), 0);
      end else begin
        vec_item_t e;
        e = sb_q.pop_front();
        check(vec_idx == e.idx, "R2 vector order", longint'(vec_idx), longint'(e.idx));
        check(tst_a == e.a && tst_b == e.b && tst_cin == e.c, "R3 R4 R5 operands",
              longint'(tst_a), longint'(e.a));
      end
    end else if (!rst && !busy) begin
      check(tst_a == '0 && tst_b == '0 && tst_cin == 1'b0, "R11 idle stimulus",
            longint'(tst_a), 0);
    end
  end

  task automatic run_selftest(input int mode, input int glitch_at, input bit after_fail);
    int exp_cnt, exp_first, busy_cycles;
    exp_cnt = 0; exp_first = 0;
    fault_mode = mode;
    for (int n = 1; n <= 10; n++) begin
      vec_item_t v;
      v = expect_vec(n);
      sb_q.push_back(v);
      if (model_add(v.a, v.b, v.c, mode) != ({1'b0, v.a} + {1'b0, v.b} + {{W{1'b0}}, v.c})) begin
        if (exp_cnt == 0) exp_first = n;
        exp_cnt++;
      end
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (after_fail)
      check(fail_count == 0 && first_fail == 0 && !done && !fail, "R10 restart clears",
            longint'(fail_count), 0);
    busy_cycles = 0;
    for (int k = 0; k < 20 && busy; k++) begin
      busy_cycles++;
      if (glitch_at != 0 && vec_idx == 4'(glitch_at)) start = 1;
      @(negedge clk);
      start = 0;
    end
    check(busy_cycles == 11, "R2 R9 busy length", busy_cycles, 11);
    check(done == 1'b1, "R8 done after run", longint'(done), 1);
    check(fail_count == 4'(exp_cnt), "R6 fail count", longint'(fail_count), exp_cnt);
    check(first_fail == 4'(exp_first), "R7 first failing vector", longint'(first_fail), exp_first);
    check(pass == (exp_cnt == 0) && fail == (exp_cnt != 0), "R8 pass/fail flags",
          longint'({pass, fail}), longint'({exp_cnt == 0, exp_cnt != 0}));
    repeat (3) @(negedge clk);
    check(done == 1'b1 && fail_count == 4'(exp_cnt), "R8 done held", longint'(done), 1);
  endtask

  task automatic check_idle(input string req);
    check(!busy && !done && !pass && !fail && vec_idx == 0 && fail_count == 0 && first_fail == 0,
          req, longint'({busy, done, pass, fail, vec_idx, fail_count, first_fail}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_idle("R1 reset state");

    run_selftest(0, 0, 0);   // good adder: pass
    run_selftest(1, 0, 0);   // flipped sum bit: every vector fails
    run_selftest(0, 0, 1);   // restart clears status (R10)
    run_selftest(2, 0, 0);   // cut carry link: vectors 4,5,6,8,9 fail
    run_selftest(3, 4, 0);   // inverted carry-out, start pulse mid-run (R9)

    // reset in the middle of a run (R1)
    fault_mode = 1;
    for (int n = 1; n <= 10; n++) sb_q.push_back(expect_vec(n));
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    sb_q.delete();
    check_idle("R1 reset mid-run");
    repeat (2) @(negedge clk);
    check_idle("R1 stays idle");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule